// File: doc/BRIEF.md
# Dual-Oscillator Counting Temperature Converter

This block turns the ratio of two pulse rates into a temperature reading. One input carries pulses from an oscillator whose frequency hardly moves with temperature (the reference). The other carries pulses from an oscillator whose frequency depends strongly on temperature (the gate). A conversion opens a measurement window that lasts a fixed number of gate pulses. During that window, a reload counter counts reference pulses. Each time it runs out, the temperature register moves up by one half-degree step and the counter reloads.

The reload interval grows by a programmable increment after every step. This slope correction straightens the nonlinear relation between pulse ratio and temperature. When the window closes, the register holds a signed reading and a one-cycle done pulse is emitted. Both pulse inputs are one-cycle strobes synchronous to the block clock. The oscillators themselves and any host-side serial link sit outside the block.

Top module: `dual_osc_tconv`

## Requirements
- R1: After reset, `temp_o` is 0 and `done_o` is 0.
- R2: A `start_i` pulse while idle begins a conversion. In the cycle after it, `temp_o` reads the base value of -55 °C. The encoding is two's complement in `TEMP_W` (9) bits with 1 LSB = 0.5 °C, so the base is -110 (9'h192).
- R3: During a conversion, the first temperature step happens on the `REF_BASE`-th counted reference pulse. Each step raises `temp_o` by exactly 1 LSB.
- R4: `slope_step_i` is sampled at the accepted start. Each reload interval after the first is longer than the one before it by that sampled amount, counted in reference pulses.
- R5: The window closes on the `GATE_BASE`-th gate pulse of the conversion. A reference pulse in that same cycle is not counted. `done_o` is high for exactly the one cycle after that gate pulse, and the reading then stays on `temp_o`.
- R6: `temp_o` never exceeds +250 (+125 °C). Steps that would pass it leave it at 250.
- R7: A `start_i` pulse during a conversion is ignored. The conversion continues with unchanged counts and gives the same result as if no pulse had come.
- R8: Outside a conversion, reference and gate pulses have no effect. `temp_o` holds its value and `done_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a conversion |
| ref_tick_i | input | 1 | Strobe, one per reference-oscillator pulse |
| gate_tick_i | input | 1 | Strobe, one per temperature-sensitive oscillator pulse |
| slope_step_i | input | SLOPE_W | Reload increment applied after each step |
| temp_o | output | TEMP_W | Signed reading, 0.5 °C per LSB |
| done_o | output | 1 | One-cycle pulse when a reading is complete |

## Verification
The bench builds the block with a reload preset of 3 and a window of 40 gate pulses. With these values a full window costs at most a few thousand cycles, yet a slow gate rate still drives the reading up through zero and into the +125 °C limit. The small preset also means that a single extra reference pulse in the closing cycle would change the result, so the exclusion of that pulse is observable. A 4-bit slope input lets the growing reload intervals stretch over several steps within one window.

// File: rtl/tconv_pkg.sv
package tconv_pkg;

  // Next reading after one step, clamped at the top of the range.
  function automatic int temp_after_step(int cur, int top);
    if (cur >= top) return top;
    return cur + 1;
  endfunction

  // Reload interval after a step: previous interval plus slope, clamped to the counter range.
  function automatic longint widen_interval(longint cur, longint inc, longint cap);
    longint sum;
    sum = cur + inc;
    if (sum > cap) return cap;
    return sum;
  endfunction

endpackage

// File: rtl/tconv_refcnt.sv
module tconv_refcnt #(
  parameter int CNT_W    = 16,
  parameter int SLOPE_W  = 8,
  parameter int REF_BASE = 100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               tick,
  input  logic [SLOPE_W-1:0] slope,
  output logic               step
);
  localparam longint CNT_MAX = (longint'(1) << CNT_W) - 1;
  localparam logic [CNT_W-1:0] PRESET = CNT_W'(REF_BASE);

  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   interval_q;
  logic [SLOPE_W-1:0] slope_q;
  logic [CNT_W-1:0]   interval_nxt;

  assign step = tick && (cnt_q == CNT_W'(1));

  always_comb begin
    interval_nxt = CNT_W'(tconv_pkg::widen_interval(longint'(interval_q),
                                                    longint'(slope_q), CNT_MAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      interval_q <= '0;
      slope_q    <= '0;
    end else if (load) begin
      cnt_q      <= PRESET;
      interval_q <= PRESET;
      slope_q    <= slope;
    end else if (step) begin
      cnt_q      <= interval_nxt;
      interval_q <= interval_nxt;
    end else if (tick) begin
      cnt_q      <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/tconv_gatecnt.sv
module tconv_gatecnt #(
  parameter int CNT_W     = 16,
  parameter int GATE_BASE = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic window_end
);
  logic [CNT_W-1:0] cnt_q;

  assign window_end = tick && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= CNT_W'(GATE_BASE);
    else if (tick) cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/tconv_accum.sv
module tconv_accum #(
  parameter int TEMP_W = 9,
  parameter int BASE_T = -110,
  parameter int MAX_T  = 250
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     inc,
  output logic signed [TEMP_W-1:0] temp
);
  logic signed [TEMP_W-1:0] temp_q;
  logic signed [TEMP_W-1:0] temp_nxt;

  always_comb temp_nxt = TEMP_W'(tconv_pkg::temp_after_step(int'(temp_q), MAX_T));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    temp_q <= '0;
    else if (load) temp_q <= TEMP_W'(BASE_T);
    else if (inc)  temp_q <= temp_nxt;
  end

  assign temp = temp_q;
endmodule

// File: rtl/dual_osc_tconv.sv
module dual_osc_tconv #(
  parameter int TEMP_W    = 9,
  parameter int BASE_T    = -110,
  parameter int MAX_T     = 250,
  parameter int CNT_W     = 16,
  parameter int SLOPE_W   = 8,
  parameter int REF_BASE  = 100,
  parameter int GATE_BASE = 1000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     ref_tick_i,
  input  logic                     gate_tick_i,
  input  logic [SLOPE_W-1:0]       slope_step_i,
  output logic signed [TEMP_W-1:0] temp_o,
  output logic                     done_o
);
  logic busy_q;
  logic done_q;
  logic conv_start;
  logic ref_en;
  logic gate_en;
  logic step_evt;
  logic window_end;

  assign conv_start = start_i && !busy_q;
  assign gate_en    = busy_q && gate_tick_i;
  assign ref_en     = busy_q && ref_tick_i && !window_end;

  tconv_gatecnt #(.CNT_W(CNT_W), .GATE_BASE(GATE_BASE)) gate_i (
    .clk(clk), .rst_n(rst_n), .load(conv_start), .tick(gate_en), .window_end(window_end)
  );

  tconv_refcnt #(.CNT_W(CNT_W), .SLOPE_W(SLOPE_W), .REF_BASE(REF_BASE)) ref_i (
    .clk(clk), .rst_n(rst_n), .load(conv_start), .tick(ref_en),
    .slope(slope_step_i), .step(step_evt)
  );

  tconv_accum #(.TEMP_W(TEMP_W), .BASE_T(BASE_T), .MAX_T(MAX_T)) acc_i (
    .clk(clk), .rst_n(rst_n), .load(conv_start), .inc(step_evt), .temp(temp_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= window_end;
      if (conv_start)      busy_q <= 1'b1;
      else if (window_end) busy_q <= 1'b0;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/dual_osc_tconv_chk.sv
module dual_osc_tconv_chk #(
  parameter int TEMP_W = 9,
  parameter int BASE_T = -110,
  parameter int MAX_T  = 250
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start_i,
  input logic                     busy,
  input logic                     conv_start,
  input logic                     step_evt,
  input logic                     window_end,
  input logic signed [TEMP_W-1:0] temp_o,
  input logic                     done_o
);
  AST_PRESET_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> (int'(temp_o) == BASE_T) && busy); // R2
  AST_STEP_ONE_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !conv_start && int'(temp_o) < MAX_T) |=> (int'(temp_o) == int'($past(temp_o)) + 1)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy); // R5
  AST_CEILING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_start && int'(temp_o) == MAX_T) |=> (int'(temp_o) == MAX_T)); // R6
  AST_RANGE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(temp_o) >= BASE_T && int'(temp_o) <= MAX_T)); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i && !window_end && !step_evt) |=> (busy && $stable(temp_o))); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !conv_start) |=> $stable(temp_o)); // R8
endmodule

bind dual_osc_tconv dual_osc_tconv_chk #(.TEMP_W(TEMP_W), .BASE_T(BASE_T), .MAX_T(MAX_T)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy(busy_q), .conv_start(conv_start),
  .step_evt(step_evt), .window_end(window_end), .temp_o(temp_o), .done_o(done_o)
);

// File: tb/dual_osc_tconv_tb_top.sv
module dual_osc_tconv_tb_top;
  localparam int TEMP_W = 9;
  localparam int BASE_T = -110;
  localparam int MAX_T = 250;
  localparam int CNT_W = 12;
  localparam int SLOPE_W = 4;
  localparam int REF_BASE = 3;
  localparam int GATE_BASE = 40;
  localparam int NVEC = 8;
  // columns: reference period, gate period, slope increment
  localparam int VEC [NVEC][3] = '{
    '{1, 1, 0}, '{1, 3, 0}, '{2, 5, 1}, '{1, 4, 2},
    '{3, 7, 0}, '{1, 30, 0}, '{1, 10, 3}, '{1, 12, 1}
  };

  logic clk = 0, rst_n = 0, start_i = 0, ref_tick_i = 0, gate_tick_i = 0;
  logic [SLOPE_W-1:0] slope_step_i = '0;
  logic signed [TEMP_W-1:0] temp_o;
  logic done_o;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dual_osc_tconv #(.TEMP_W(TEMP_W), .BASE_T(BASE_T), .MAX_T(MAX_T), .CNT_W(CNT_W),
    .SLOPE_W(SLOPE_W), .REF_BASE(REF_BASE), .GATE_BASE(GATE_BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ref_tick_i(ref_tick_i),
    .gate_tick_i(gate_tick_i), .slope_step_i(slope_step_i), .temp_o(temp_o), .done_o(done_o));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected reading from the number of counted reference pulses:
  // consume intervals REF_BASE, REF_BASE+s, REF_BASE+2s, ... while they fit.
  function automatic int expect_temp(int nref, int s);
    int left = nref, need = REF_BASE, t = BASE_T;
    while (left >= need) begin
      left -= need;
      if (t < MAX_T) t++;
      need += s;
      if (need > (1 << CNT_W) - 1) need = (1 << CNT_W) - 1;
    end
    return t;
  endfunction

  task automatic run_conv(int rp, int gp, int s, bit mid_start);
    int gcnt = 0, nref = 0, c = 0;
    bit r, g;
    @(negedge clk);
    start_i = 1; slope_step_i = SLOPE_W'(s);
    @(negedge clk);
    start_i = 0; slope_step_i = '0;
    check("R2 preset", int'(temp_o), BASE_T);
    forever begin
      r = (c % rp) == rp - 1;
      g = (c % gp) == gp - 1;
      ref_tick_i = r; gate_tick_i = g;
      start_i = mid_start && (c == 5);
      if (g) gcnt++;
      if (gcnt == GATE_BASE) break;
      if (r) nref++;
      @(negedge clk);
      if (done_o) check("R5 early done", 1, 0);
      c++;
    end
    @(negedge clk);
    ref_tick_i = 0; gate_tick_i = 0; start_i = 0;
    check("R5 done pulse", int'(done_o), 1);
    check(mid_start ? "R7 result" : (s != 0 ? "R4 result" : "R3 R6 result"),
          int'(temp_o), expect_temp(nref, s));
    @(negedge clk);
    check("R5 done falls", int'(done_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hold;
    repeat (3) @(negedge clk);
    check("R1 reset temp", int'(temp_o), 0);
    check("R1 reset done", int'(done_o), 0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NVEC; i++) run_conv(VEC[i][0], VEC[i][1], VEC[i][2], 1'b0);
    // R7: extra start in the middle of a conversion
    run_conv(1, 3, 0, 1'b1);
    run_conv(2, 9, 2, 1'b1);
    // R8: pulses while idle leave the reading alone
    hold = int'(temp_o);
    for (int k = 0; k < 25; k++) begin
      ref_tick_i = 1; gate_tick_i = (k % 2) == 0;
      @(negedge clk);
      if (done_o) check("R8 idle done", 1, 0);
    end
    ref_tick_i = 0; gate_tick_i = 0;
    @(negedge clk);
    check("R8 idle hold", int'(temp_o), hold);
    check("R8 idle no done", int'(done_o), 0);
    // R6: saturated window followed by a fresh start back at base
    run_conv(1, 40, 0, 1'b0);
    run_conv(1, 1, 0, 1'b0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule